// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 32-bit virtual address into a physical address for a 32-bit processor core. A single lookup path handles two kinds of address space. Fixed windows in the upper half of the address space map to physical memory by subtracting a constant. The remaining space goes through a fully associative translation buffer with 16 entries, where each entry describes an even/odd pair of 4 KiB pages.

Each request carries the address, a store flag, a user-mode flag, an error-level flag and the current 8-bit address-space tag. The result appears one clock later as a physical address, a write-permission bit and a fault class. When a request faults, the block records the faulting address in a bad-address register. It also overwrites the page-number fields (bits 31:12) of a context register and an entry-high register, and leaves their low 12 bits untouched. A one-cycle write port loads any translation entry by index.

Top module: `va_translator`

## Requirements
- R1: In user mode, a request whose address has bit 31 set reports an address-error fault (faultClass 1), whatever the other inputs are.
- R2: An address below 0x80000000 with the error-level flag set is passed through unchanged as the physical address, with write permission set and no fault.
- R3: Outside user mode, addresses 0x80000000..0x9FFFFFFF map to address minus 0x80000000, and 0xA0000000..0xBFFFFFFF map to address minus 0xA0000000. Both ranges are writable and never fault.
- R4: Addresses below 0x80000000 without the error-level flag, and all addresses at 0xC0000000 and above, are looked up in all entries. An entry matches when its page-pair number equals address bits 31:13, the address is strictly below the entry's end bound, and the entry is global or its tag equals the current tag. When several entries match, the lowest index is used.
- R5: Address bit 12 selects the even (0) or odd (1) half of the matching entry. The physical address is that half's 20-bit frame number followed by address bits 11:0.
- R6: A looked-up address that matches no entry reports a miss fault (faultClass 2).
- R7: A match on a half whose valid bit is clear reports an invalid fault (faultClass 3). A store that matches a valid half whose dirty bit is clear reports a modify fault (faultClass 4). faultClass 0 means no fault.
- R8: After a translated match, write permission equals the dirty bit of the selected half. On any fault, write permission and the physical address are 0.
- R9: On a fault, the bad-address register takes the full address, and bits 31:12 of the context and entry-high registers take address bits 31:12 while their bits 11:0 are kept. Without a fault, all three registers keep their values. All three reset to 0.
- R10: The result of a request appears on the clock edge after it is presented, with rspValid high for exactly that cycle. Exactly one of rspHit and a nonzero faultClass is set, and faultWrite repeats the store flag of the request.
- R11: A write-port strobe updates every field of the indexed entry on one clock edge, and later lookups see the new contents. After reset, every entry is invalid and non-global and matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A translation request is presented this cycle |
| reqAddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 for a store, 0 for a load |
| userMode | input | 1 | Request issued in user mode |
| errLevel | input | 1 | Error-level flag; low addresses bypass translation |
| curAsid | input | 8 | Current address-space tag |
| tlbWrEn | input | 1 | Load one translation entry |
| tlbWrIdx | input | 4 | Entry index to load |
| tlbWrVpn | input | 19 | Page-pair number (address bits 31:13) |
| tlbWrEnd | input | 32 | Exclusive upper address bound of the entry |
| tlbWrAsid | input | 8 | Entry address-space tag |
| tlbWrGlobal | input | 1 | Entry matches any tag |
| tlbWrValid | input | 2 | Valid bits, bit 0 even half, bit 1 odd half |
| tlbWrDirty | input | 2 | Dirty (writable) bits, bit 0 even half, bit 1 odd half |
| tlbWrPfnEven | input | 20 | Frame number of the even half |
| tlbWrPfnOdd | input | 20 | Frame number of the odd half |
| rspValid | output | 1 | Result of the previous cycle's request |
| rspHit | output | 1 | Translation succeeded |
| physAddr | output | 32 | Physical address (0 on fault) |
| rspWritable | output | 1 | Write permission of the translation |
| faultClass | output | 3 | 0 none, 1 address error, 2 miss, 3 invalid, 4 modify |
| faultWrite | output | 1 | Store flag of the answered request |
| badAddr | output | 32 | Last faulting address |
| contextReg | output | 32 | Context register |
| entryHiReg | output | 32 | Entry-high register |

## Verification
The bound checker watches every cycle for the following. A user-mode access to the upper half always gives an address error. The two fixed windows return the subtracted address with write permission. Error-level pass-through returns the address unchanged. Every response carries exactly one outcome. A modify fault only answers a store, and a fault never grants write permission. On a fault, the fault registers take the request's address, and on idle cycles they hold.

The translation buffer's matching rules need the bench's scenarios and its behavioural model. These rules are the tag and global comparison, the end bound, the choice of half by bit 12, the lowest-index priority, and the effect of rewriting an entry. A property cannot know the stored entries, so only the model can predict these outcomes.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int ASID_W     = 8;
  localparam int VPN_W      = ADDR_W - PAGE_SHIFT - 1;
  localparam int PFN_W      = ADDR_W - PAGE_SHIFT;

  localparam logic [ADDR_W-1:0] WIN0_BASE = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] WIN1_BASE = 32'hA000_0000;

  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_ADDR_ERR = 3'd1,
    FC_MISS     = 3'd2,
    FC_INVALID  = 3'd3,
    FC_MODIFY   = 3'd4
  } faultClass_e;

  typedef enum logic [1:0] {
    PS_PASS = 2'd0,
    PS_WIN0 = 2'd1,
    PS_WIN1 = 2'd2,
    PS_TLB  = 2'd3
  } physSel_e;

  typedef struct packed {
    logic        capture;
    logic        recordFault;
    physSel_e    physSel;
    faultClass_e fclass;
    logic        writable;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ADDR_W-1:0] endBound;
    logic [ASID_W-1:0] asid;
    logic              isGlobal;
    logic [1:0]        valid;
    logic [1:0]        dirty;
    logic [PFN_W-1:0]  pfnEven;
    logic [PFN_W-1:0]  pfnOdd;
  } tlbEntry_t;
endpackage

// File: rtl/va_xlate_ctrl.sv
module va_xlate_ctrl
  import va_xlate_pkg::*;
(
  input  logic        reqValid,
  input  logic [2:0]  addrTop,
  input  logic        reqWrite,
  input  logic        userMode,
  input  logic        errLevel,
  input  logic        tlbHit,
  input  logic        selValid,
  input  logic        selDirty,
  output ctrlStrobe_t strobe
);
  logic upperHalf;
  assign upperHalf = addrTop[2];

  always_comb begin
    strobe          = '0;
    strobe.capture  = reqValid;
    strobe.physSel  = PS_TLB;
    strobe.fclass   = FC_NONE;
    strobe.writable = 1'b0;

    if (userMode && upperHalf) begin
      // user mode may only reach the lower half
      strobe.fclass = FC_ADDR_ERR;
    end else if (!upperHalf && errLevel) begin
      strobe.physSel  = PS_PASS;
      strobe.writable = 1'b1;
    end else if (addrTop == 3'b100) begin
      strobe.physSel  = PS_WIN0;
      strobe.writable = 1'b1;
    end else if (addrTop == 3'b101) begin
      strobe.physSel  = PS_WIN1;
      strobe.writable = 1'b1;
    end else begin
      strobe.physSel = PS_TLB;
      if (!tlbHit) begin
        strobe.fclass = FC_MISS;
      end else if (!selValid) begin
        strobe.fclass = FC_INVALID;
      end else if (reqWrite && !selDirty) begin
        strobe.fclass = FC_MODIFY;
      end else begin
        strobe.writable = selDirty;
      end
    end

    strobe.recordFault = reqValid && (strobe.fclass != FC_NONE);
  end
endmodule

// File: rtl/va_xlate_dp.sv
module va_xlate_dp
  import va_xlate_pkg::*;
#(
  parameter int TLB_ENTRIES = 16,
  localparam int IDX_W = $clog2(TLB_ENTRIES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              tlbWrEn,
  input  logic [IDX_W-1:0]  tlbWrIdx,
  input  tlbEntry_t         tlbWrData,
  input  ctrlStrobe_t       strobe,
  output logic              tlbHit,
  output logic              selValid,
  output logic              selDirty,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] physAddr,
  output logic              rspWritable,
  output logic [2:0]        faultClass,
  output logic              faultWrite,
  output logic [ADDR_W-1:0] badAddr,
  output logic [ADDR_W-1:0] contextReg,
  output logic [ADDR_W-1:0] entryHiReg
);
  tlbEntry_t              tlbMem [TLB_ENTRIES];
  logic [TLB_ENTRIES-1:0] matchVec;
  logic                   oddHalf;
  logic [PFN_W-1:0]       selPfn;
  logic [ADDR_W-1:0]      physNext;

  assign oddHalf = reqAddr[PAGE_SHIFT];

  // entry storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TLB_ENTRIES; i++) tlbMem[i] <= '0;
    end else if (tlbWrEn) begin
      tlbMem[tlbWrIdx] <= tlbWrData;
    end
  end

  // parallel comparators
  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : gCmp
    logic vpnEq, inBound, asidOk;
    assign vpnEq   = tlbMem[g].vpn == reqAddr[ADDR_W-1:PAGE_SHIFT+1];
    assign inBound = reqAddr < tlbMem[g].endBound;
    assign asidOk  = tlbMem[g].isGlobal || (tlbMem[g].asid == curAsid);
    assign matchVec[g] = vpnEq && inBound && asidOk;
  end

  // lowest matching index wins
  always_comb begin
    tlbHit   = |matchVec;
    selValid = 1'b0;
    selDirty = 1'b0;
    selPfn   = '0;
    for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        selValid = tlbMem[i].valid[oddHalf];
        selDirty = tlbMem[i].dirty[oddHalf];
        selPfn   = oddHalf ? tlbMem[i].pfnOdd : tlbMem[i].pfnEven;
      end
    end
  end

  always_comb begin
    unique case (strobe.physSel)
      PS_PASS: physNext = reqAddr;
      PS_WIN0: physNext = reqAddr - WIN0_BASE;
      PS_WIN1: physNext = reqAddr - WIN1_BASE;
      default: physNext = {selPfn, reqAddr[PAGE_SHIFT-1:0]};
    endcase
    if (strobe.fclass != FC_NONE) physNext = '0;
  end

  // response stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      physAddr    <= '0;
      rspWritable <= 1'b0;
      faultClass  <= FC_NONE;
      faultWrite  <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      rspHit   <= strobe.capture && (strobe.fclass == FC_NONE);
      if (strobe.capture) begin
        physAddr    <= physNext;
        rspWritable <= strobe.writable;
        faultClass  <= strobe.fclass;
        faultWrite  <= reqWrite;
      end
    end
  end

  // fault side-effect registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badAddr    <= '0;
      contextReg <= '0;
      entryHiReg <= '0;
    end else if (strobe.recordFault) begin
      badAddr    <= reqAddr;
      contextReg <= {reqAddr[ADDR_W-1:PAGE_SHIFT], contextReg[PAGE_SHIFT-1:0]};
      entryHiReg <= {reqAddr[ADDR_W-1:PAGE_SHIFT], entryHiReg[PAGE_SHIFT-1:0]};
    end
  end
endmodule

// File: rtl/va_translator.sv
module va_translator
  import va_xlate_pkg::*;
#(
  parameter int TLB_ENTRIES = 16
)(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [31:0]                    reqAddr,
  input  logic                           reqWrite,
  input  logic                           userMode,
  input  logic                           errLevel,
  input  logic [7:0]                     curAsid,
  input  logic                           tlbWrEn,
  input  logic [$clog2(TLB_ENTRIES)-1:0] tlbWrIdx,
  input  logic [18:0]                    tlbWrVpn,
  input  logic [31:0]                    tlbWrEnd,
  input  logic [7:0]                     tlbWrAsid,
  input  logic                           tlbWrGlobal,
  input  logic [1:0]                     tlbWrValid,
  input  logic [1:0]                     tlbWrDirty,
  input  logic [19:0]                    tlbWrPfnEven,
  input  logic [19:0]                    tlbWrPfnOdd,
  output logic                           rspValid,
  output logic                           rspHit,
  output logic [31:0]                    physAddr,
  output logic                           rspWritable,
  output logic [2:0]                     faultClass,
  output logic                           faultWrite,
  output logic [31:0]                    badAddr,
  output logic [31:0]                    contextReg,
  output logic [31:0]                    entryHiReg
);
  ctrlStrobe_t strobe;
  tlbEntry_t   wrData;
  logic        tlbHit, selValid, selDirty;

  always_comb begin
    wrData.vpn      = tlbWrVpn;
    wrData.endBound = tlbWrEnd;
    wrData.asid     = tlbWrAsid;
    wrData.isGlobal = tlbWrGlobal;
    wrData.valid    = tlbWrValid;
    wrData.dirty    = tlbWrDirty;
    wrData.pfnEven  = tlbWrPfnEven;
    wrData.pfnOdd   = tlbWrPfnOdd;
  end

  va_xlate_ctrl u_ctrl (
    .reqValid (reqValid),
    .addrTop  (reqAddr[31:29]),
    .reqWrite (reqWrite),
    .userMode (userMode),
    .errLevel (errLevel),
    .tlbHit   (tlbHit),
    .selValid (selValid),
    .selDirty (selDirty),
    .strobe   (strobe)
  );

  va_xlate_dp #(.TLB_ENTRIES(TLB_ENTRIES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .curAsid     (curAsid),
    .tlbWrEn     (tlbWrEn),
    .tlbWrIdx    (tlbWrIdx),
    .tlbWrData   (wrData),
    .strobe      (strobe),
    .tlbHit      (tlbHit),
    .selValid    (selValid),
    .selDirty    (selDirty),
    .rspValid    (rspValid),
    .rspHit      (rspHit),
    .physAddr    (physAddr),
    .rspWritable (rspWritable),
    .faultClass  (faultClass),
    .faultWrite  (faultWrite),
    .badAddr     (badAddr),
    .contextReg  (contextReg),
    .entryHiReg  (entryHiReg)
  );
endmodule

// File: rtl/va_xlate_chk.sv
module va_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic        reqWrite,
  input logic        userMode,
  input logic        errLevel,
  input logic        rspValid,
  input logic        rspHit,
  input logic [31:0] physAddr,
  input logic        rspWritable,
  input logic [2:0]  faultClass,
  input logic        faultWrite,
  input logic [31:0] badAddr,
  input logic [31:0] contextReg,
  input logic [31:0] entryHiReg
);
  p_user_upper_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && userMode && reqAddr[31] |=> faultClass == 3'd1 && !rspHit);

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAddr[31] && errLevel |=> physAddr == $past(reqAddr) && rspWritable);

  p_win0_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !userMode && reqAddr[31:29] == 3'b100
    |=> physAddr == $past(reqAddr) - 32'h8000_0000 && rspWritable && rspHit);

  p_win1_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !userMode && reqAddr[31:29] == 3'b101
    |=> physAddr == $past(reqAddr) - 32'hA000_0000 && rspWritable && rspHit);

  p_modify_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && faultClass == 3'd4 |-> faultWrite);

  p_fault_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && faultClass != 3'd0 |-> !rspWritable && physAddr == 32'h0);

  p_fault_regs_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> faultClass == 3'd0 ||
      (badAddr == $past(reqAddr) && contextReg[31:12] == $past(reqAddr[31:12])
       && entryHiReg[31:12] == $past(reqAddr[31:12])));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(badAddr) && $stable(contextReg) && $stable(entryHiReg));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, faultClass != 3'd0}) == 1);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid && faultWrite == $past(reqWrite));

  p_no_idle_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspHit);
endmodule

bind va_translator va_xlate_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqAddr     (reqAddr),
  .reqWrite    (reqWrite),
  .userMode    (userMode),
  .errLevel    (errLevel),
  .rspValid    (rspValid),
  .rspHit      (rspHit),
  .physAddr    (physAddr),
  .rspWritable (rspWritable),
  .faultClass  (faultClass),
  .faultWrite  (faultWrite),
  .badAddr     (badAddr),
  .contextReg  (contextReg),
  .entryHiReg  (entryHiReg)
);

// File: tb/va_translator_tb.sv
module va_translator_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        userMode = 1'b0;
  logic        errLevel = 1'b0;
  logic [7:0]  curAsid = '0;
  logic        tlbWrEn = 1'b0;
  logic [3:0]  tlbWrIdx = '0;
  logic [18:0] tlbWrVpn = '0;
  logic [31:0] tlbWrEnd = '0;
  logic [7:0]  tlbWrAsid = '0;
  logic        tlbWrGlobal = 1'b0;
  logic [1:0]  tlbWrValid = '0;
  logic [1:0]  tlbWrDirty = '0;
  logic [19:0] tlbWrPfnEven = '0;
  logic [19:0] tlbWrPfnOdd = '0;
  logic        rspValid, rspHit, rspWritable, faultWrite;
  logic [31:0] physAddr, badAddr, contextReg, entryHiReg;
  logic [2:0]  faultClass;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  // behavioural model state
  logic [18:0] mVpn [16];
  logic [31:0] mEnd [16];
  logic [7:0]  mAsid [16];
  bit          mGlob [16];
  logic [1:0]  mVal [16];
  logic [1:0]  mDir [16];
  logic [19:0] mPfnE [16];
  logic [19:0] mPfnO [16];
  logic [31:0] mBad = '0, mCtx = '0, mEhi = '0;
  logic [31:0] ePhys;
  logic [2:0]  eClass;
  bit          eWr;

  always #5 clk = ~clk;

  va_translator u_dut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic predict(logic [31:0] a, bit wr, bit usr, bit erl, logic [7:0] asid);
    int hitIdx;
    bit half;
    hitIdx = -1;
    eClass = 3'd0; ePhys = '0; eWr = 0;
    if (usr && a >= 32'h8000_0000) eClass = 3'd1;
    else if (a < 32'h8000_0000 && erl) begin ePhys = a; eWr = 1; end
    else if (a >= 32'h8000_0000 && a < 32'hA000_0000) begin ePhys = a - 32'h8000_0000; eWr = 1; end
    else if (a >= 32'hA000_0000 && a < 32'hC000_0000) begin ePhys = a - 32'hA000_0000; eWr = 1; end
    else begin
      for (int i = 15; i >= 0; i--)
        if (mVpn[i] == a[31:13] && a < mEnd[i] && (mGlob[i] || mAsid[i] == asid)) hitIdx = i;
      if (hitIdx < 0) eClass = 3'd2;
      else begin
        half = a[12];
        if (!mVal[hitIdx][half]) eClass = 3'd3;
        else if (wr && !mDir[hitIdx][half]) eClass = 3'd4;
        else begin
          eWr = mDir[hitIdx][half];
          ePhys = {(half ? mPfnO[hitIdx] : mPfnE[hitIdx]), a[11:0]};
        end
      end
    end
    if (eClass != 3'd0) begin
      mBad = a;
      mCtx = {a[31:12], mCtx[11:0]};
      mEhi = {a[31:12], mEhi[11:0]};
    end
  endtask

  task automatic doReq(string req, logic [31:0] a, bit wr, bit usr, bit erl, logic [7:0] asid);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; userMode = usr; errLevel = erl; curAsid = asid;
    predict(a, wr, usr, erl, asid);
    @(negedge clk);
    reqValid = 1'b0;
    chk(req, "rspValid R10", {31'b0, rspValid}, 32'd1);
    chk(req, "rspHit R10", {31'b0, rspHit}, {31'b0, eClass == 3'd0});
    chk(req, "faultClass", {29'b0, faultClass}, {29'b0, eClass});
    chk(req, "faultWrite R10", {31'b0, faultWrite}, {31'b0, wr});
    chk(req, "physAddr", physAddr, ePhys);
    chk(req, "writable R8", {31'b0, rspWritable}, {31'b0, eWr});
    chk(req, "badAddr R9", badAddr, mBad);
    chk(req, "context R9", contextReg, mCtx);
    chk(req, "entryHi R9", entryHiReg, mEhi);
  endtask

  task automatic tlbLoad(int idx, logic [31:0] va, logic [31:0] endB, logic [7:0] asid, bit g,
                         logic [1:0] v, logic [1:0] d, logic [19:0] pe, logic [19:0] po);
    @(negedge clk);
    tlbWrEn = 1'b1; tlbWrIdx = idx[3:0]; tlbWrVpn = va[31:13]; tlbWrEnd = endB;
    tlbWrAsid = asid; tlbWrGlobal = g; tlbWrValid = v; tlbWrDirty = d;
    tlbWrPfnEven = pe; tlbWrPfnOdd = po;
    mVpn[idx] = va[31:13]; mEnd[idx] = endB; mAsid[idx] = asid; mGlob[idx] = g;
    mVal[idx] = v; mDir[idx] = d; mPfnE[idx] = pe; mPfnO[idx] = po;
    @(negedge clk);
    tlbWrEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mVpn[i] = '0; mEnd[i] = '0; mAsid[i] = '0; mGlob[i] = 0;
      mVal[i] = '0; mDir[i] = '0; mPfnE[i] = '0; mPfnO[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", "reset rspValid", {31'b0, rspValid}, 32'd0);
    chk("R9", "reset badAddr", badAddr, 32'd0);
    chk("R9", "reset entryHi", entryHiReg, 32'd0);

    // R11: cleared buffer matches nothing, even address 0 with tag 0
    doReq("R11", 32'h0000_0000, 0, 0, 0, 8'd0);
    doReq("R11", 32'hC000_0000, 0, 0, 0, 8'd0);
    @(negedge clk);
    chk("R10", "idle rspValid", {31'b0, rspValid}, 32'd0);

    doReq("R1", 32'h8000_0000, 0, 1, 0, 8'd0);
    doReq("R1", 32'hFFFF_F123, 1, 1, 1, 8'd0);
    doReq("R2", 32'h1234_5678, 1, 0, 1, 8'd0);
    doReq("R2", 32'h7FFF_FFFF, 0, 1, 1, 8'd3);
    doReq("R3", 32'h8123_4567, 1, 0, 0, 8'd0);
    doReq("R3", 32'hA123_4567, 0, 0, 1, 8'd0);
    doReq("R3", 32'hBFFF_FFFC, 1, 0, 0, 8'd0);

    tlbLoad(0, 32'h0040_0000, 32'h0040_2000, 8'd5, 0, 2'b11, 2'b01, 20'h11111, 20'h22222);
    tlbLoad(1, 32'hC010_0000, 32'hFFFF_FFFF, 8'd9, 1, 2'b10, 2'b10, 20'h33333, 20'h44444);
    tlbLoad(2, 32'h1000_0000, 32'h1000_1000, 8'd5, 0, 2'b11, 2'b11, 20'h55555, 20'h66666);
    tlbLoad(3, 32'h0040_0000, 32'h0040_2000, 8'd7, 0, 2'b11, 2'b11, 20'h77777, 20'h88888);
    tlbLoad(5, 32'h0060_0000, 32'h0060_2000, 8'd1, 1, 2'b11, 2'b11, 20'hAAAAA, 20'hBBBBB);
    tlbLoad(4, 32'h0060_0000, 32'h0060_2000, 8'd1, 0, 2'b11, 2'b00, 20'hCCCCC, 20'hDDDDD);

    doReq("R4 R5", 32'h0040_0ABC, 1, 0, 0, 8'd5);
    doReq("R5 R8", 32'h0040_1ABC, 0, 1, 0, 8'd5);
    doReq("R7", 32'h0040_1ABC, 1, 0, 0, 8'd5);
    doReq("R4 R6", 32'h0040_0ABC, 0, 0, 0, 8'd6);
    doReq("R4", 32'h0040_1004, 1, 0, 0, 8'd7);
    doReq("R4 R7", 32'hC010_0010, 0, 0, 0, 8'd2);
    doReq("R4 R5", 32'hC010_1010, 1, 0, 0, 8'd2);
    doReq("R4", 32'h1000_0004, 0, 1, 0, 8'd5);
    doReq("R4 R6", 32'h1000_1004, 0, 0, 0, 8'd5);
    doReq("R4", 32'h0060_0100, 0, 0, 0, 8'd1);
    doReq("R7", 32'h0060_1100, 1, 0, 0, 8'd1);
    doReq("R6", 32'hE000_0000, 1, 0, 0, 8'd0);
    @(negedge clk);
    chk("R9", "idle badAddr", badAddr, mBad);

    tlbLoad(0, 32'h0040_0000, 32'h0040_2000, 8'd5, 0, 2'b01, 2'b11, 20'h9999A, 20'h9999B);
    doReq("R11", 32'h0040_0010, 1, 0, 0, 8'd5);
    doReq("R11", 32'h0040_1010, 0, 0, 0, 8'd5);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule